// File: doc/BRIEF.md
# Serial Wait and DMA Request Line

This block drives the single active-low wait/request line of one serial channel. Three configuration bits set its role. The first turns the function on. The second picks wait duty (it stalls the CPU bus) or request duty (it asks an external DMA engine to move a character). The third picks which buffer is tracked: receive or transmit.

In wait duty the line goes low while the CPU is trying to read a character that has not arrived. It also goes low while the CPU is trying to write into a transmit buffer that is still full.

In request duty the line goes low whenever the tracked buffer needs service. A new request is never allowed to appear in the middle of a bus cycle that selects the channel. On transmit, in synchronous or framed operation, the block also puts a one-clock low pulse on the line when CRC transmission finishes. This lets the DMA engine start the next block at once.

The line is registered. Every decision appears one clock after the inputs that caused it.

Top module: `serial_wreq_ctrl`

## Requirements
- R1: While `rst_ni` is low, `wreq_no` is 1 (inactive).
- R2: With `fn_en_i` = 0, `wreq_no` is 1 one clock later, whatever the other inputs are.
- R3: In wait duty (`req_mode_i` = 0) with `dir_tx_i` = 0, `wreq_no` is 0 one clock after a cycle with `cs_i`=1, `rd_i`=1 and `rx_avail_i`=0. If `rx_avail_i`=1, it stays 1.
- R4: In wait duty with `dir_tx_i` = 1, `wreq_no` is 0 one clock after a cycle with `cs_i`=1, `wr_i`=1 and `tx_empty_i`=0. A read strobe alone does not assert it.
- R5: In wait duty, `wreq_no` returns to 1 one clock after the stalling condition clears.
- R6: In request duty (`req_mode_i` = 1) with `dir_tx_i` = 0 and no bus cycle, `wreq_no` follows `!rx_avail_i` with one clock of delay.
- R7: In request duty with `dir_tx_i` = 1 and no bus cycle, `wreq_no` follows `!tx_empty_i` with one clock of delay.
- R8: In request duty, a request cannot become active while a bus cycle (`cs_i` and (`rd_i` or `wr_i`)) is in progress. It appears one clock after the bus cycle ends.
- R9: In request duty, a request that is already active stays active through a bus cycle as long as its buffer condition holds.
- R10: In request duty with `dir_tx_i`=1 and `sync_mode_i`=1, a rising edge of `crc_end_i` drives `wreq_no` low for exactly one clock, one clock later. This holds even if `crc_end_i` stays high, even during a bus cycle, and even when the buffer condition is inactive.
- R11: A rising edge of `crc_end_i` has no effect on `wreq_no` when `sync_mode_i`=0, when `dir_tx_i`=0, or in wait duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fn_en_i | input | 1 | Wait/request function enable |
| req_mode_i | input | 1 | 1 = request duty, 0 = wait duty |
| dir_tx_i | input | 1 | 1 = track transmit buffer, 0 = receive buffer |
| cs_i | input | 1 | Channel selected by the CPU |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rx_avail_i | input | 1 | Receive buffer holds a character |
| tx_empty_i | input | 1 | Transmit buffer empty (0 = full) |
| crc_end_i | input | 1 | End-of-CRC-transmission event |
| sync_mode_i | input | 1 | Synchronous or framed operation active |
| wreq_no | output | 1 | Shared wait/request line, active low |

## Verification
Two functions can fall in the same cycle: the end-of-CRC pulse and the hold-off of a new request during a bus cycle. The bench provokes this by raising `crc_end_i` while a write cycle selects the channel and the transmit buffer is full. It then expects the pulse to go out anyway, for exactly one clock, and the line to go back to high afterwards. A second overlap occurs when a request is already active as a bus cycle starts. Here the bench judges that the line stays low and is not dropped.

// File: rtl/wreq_pkg.sv
package wreq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_REQ  = 2'd2
  } wreq_mode_e;
endpackage

// File: rtl/wreq_wait_gen.sv
module wreq_wait_gen (
  input  logic dir_tx_i,
  input  logic cs_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic rx_avail_i,
  input  logic tx_empty_i,
  output logic stall_o
);
  logic rx_stall, tx_stall;

  assign rx_stall = !dir_tx_i && cs_i && rd_i && !rx_avail_i;
  assign tx_stall =  dir_tx_i && cs_i && wr_i && !tx_empty_i;
  assign stall_o  = rx_stall || tx_stall;
endmodule

// File: rtl/wreq_req_gen.sv
module wreq_req_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_tx_i,
  input  logic sync_mode_i,
  input  logic bus_busy_i,
  input  logic rx_avail_i,
  input  logic tx_empty_i,
  input  logic crc_end_i,
  input  logic active_i,
  output logic pulse_o,
  output logic req_o
);
  logic crc_q, need;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= 1'b0;
    else         crc_q <= crc_end_i;
  end

  assign need    = dir_tx_i ? tx_empty_i : rx_avail_i;
  // edge-detected so a held event yields a single pulse
  assign pulse_o = crc_end_i && !crc_q && dir_tx_i && sync_mode_i;
  // a request may drop at any time but only rises outside a bus cycle
  assign req_o   = (need && (!bus_busy_i || active_i)) || pulse_o;

  // R10
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/serial_wreq_ctrl.sv
module serial_wreq_ctrl
  import wreq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fn_en_i,
  input  logic req_mode_i,
  input  logic dir_tx_i,
  input  logic cs_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic rx_avail_i,
  input  logic tx_empty_i,
  input  logic crc_end_i,
  input  logic sync_mode_i,
  output logic wreq_no
);
  wreq_mode_e mode;
  logic bus_busy, stall, req, pulse, out_q, out_d;

  assign mode     = !fn_en_i ? MODE_OFF : (req_mode_i ? MODE_REQ : MODE_WAIT);
  assign bus_busy = cs_i && (rd_i || wr_i);

  wreq_wait_gen u_wait (
    .dir_tx_i   (dir_tx_i),
    .cs_i       (cs_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .rx_avail_i (rx_avail_i),
    .tx_empty_i (tx_empty_i),
    .stall_o    (stall)
  );

  wreq_req_gen u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_tx_i    (dir_tx_i),
    .sync_mode_i (sync_mode_i),
    .bus_busy_i  (bus_busy),
    .rx_avail_i  (rx_avail_i),
    .tx_empty_i  (tx_empty_i),
    .crc_end_i   (crc_end_i),
    .active_i    (out_q),
    .pulse_o     (pulse),
    .req_o       (req)
  );

  always_comb begin
    unique case (mode)
      MODE_WAIT: out_d = stall;
      MODE_REQ:  out_d = req;
      default:   out_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign wreq_no = !out_q;

  // R2
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fn_en_i |=> wreq_no);

  // R3
  wait_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_en_i && !req_mode_i && !dir_tx_i && cs_i && rd_i && !rx_avail_i) |=> !wreq_no);

  // R5
  wait_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_WAIT && !stall) |=> wreq_no);

  // R8
  holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_REQ && bus_busy && wreq_no && !pulse) |=> wreq_no);

  // R10
  pulse_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_REQ && pulse) |=> !wreq_no);
endmodule

// File: tb/serial_wreq_ctrl_bench.sv
`timescale 1ns/1ps
module serial_wreq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fn_en, req_mode, dir_tx, cs, rd, wr, rx_avail, tx_empty, crc_end, sync_mode;
  logic wreq_n;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  serial_wreq_ctrl u_serial_wreq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .fn_en_i(fn_en), .req_mode_i(req_mode),
    .dir_tx_i(dir_tx), .cs_i(cs), .rd_i(rd), .wr_i(wr), .rx_avail_i(rx_avail),
    .tx_empty_i(tx_empty), .crc_end_i(crc_end), .sync_mode_i(sync_mode),
    .wreq_no(wreq_n)
  );

  task automatic idle();
    fn_en = 0; req_mode = 0; dir_tx = 0; cs = 0; rd = 0; wr = 0;
    rx_avail = 0; tx_empty = 0; crc_end = 0; sync_mode = 0;
  endtask

  // advance one edge; sample away from it
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    checks++;
    if (wreq_n !== exp) begin
      failures++;
      $display("FAIL %s wreq_no=%b expected=%b", req, wreq_n, exp);
    end
  endtask

  task automatic t_reset();
    idle();
    #1 check("R1", 1'b1);
    tick();
    check("R1", 1'b1);
    rst_n = 1'b1;
    tick();
    check("R1", 1'b1);
  endtask

  task automatic t_disabled();
    idle(); cs = 1; rd = 1; tick();
    check("R2", 1'b1);
    req_mode = 1; cs = 0; rd = 0; rx_avail = 1; tick();
    check("R2", 1'b1);
    idle(); tick();
  endtask

  task automatic t_wait_rx();
    idle(); fn_en = 1; cs = 1; rd = 1; rx_avail = 1; tick();
    check("R3", 1'b1);
    rx_avail = 0; tick();
    check("R3", 1'b0);
    tick();
    check("R3", 1'b0);
    rx_avail = 1; tick();
    check("R5", 1'b1);
    idle(); tick();
  endtask

  task automatic t_wait_tx();
    idle(); fn_en = 1; dir_tx = 1; cs = 1; rd = 1; tick();
    check("R4", 1'b1);
    rd = 0; wr = 1; tick();
    check("R4", 1'b0);
    tx_empty = 1; tick();
    check("R5", 1'b1);
    tx_empty = 0; tick();
    check("R4", 1'b0);
    cs = 0; tick();
    check("R5", 1'b1);
    idle(); tick();
  endtask

  task automatic t_req_rx();
    idle(); fn_en = 1; req_mode = 1; tick();
    check("R6", 1'b1);
    rx_avail = 1; tick();
    check("R6", 1'b0);
    rx_avail = 0; tick();
    check("R6", 1'b1);
    idle(); tick();
  endtask

  task automatic t_req_tx();
    idle(); fn_en = 1; req_mode = 1; dir_tx = 1; tx_empty = 1; tick();
    check("R7", 1'b0);
    tx_empty = 0; tick();
    check("R7", 1'b1);
    idle(); tick();
  endtask

  task automatic t_holdoff();
    idle(); fn_en = 1; req_mode = 1; cs = 1; rd = 1; rx_avail = 1; tick();
    check("R8", 1'b1);
    tick();
    check("R8", 1'b1);
    cs = 0; rd = 0; tick();
    check("R8", 1'b0);
    cs = 1; wr = 1; tick();
    check("R9", 1'b0);
    rx_avail = 0; tick();
    check("R9", 1'b1);
    idle(); tick();
  endtask

  task automatic t_crc_pulse();
    idle(); fn_en = 1; req_mode = 1; dir_tx = 1; sync_mode = 1; tick();
    crc_end = 1; tick();
    check("R10", 1'b0);
    tick();
    check("R10", 1'b1);
    tick();
    check("R10", 1'b1);
    crc_end = 0; tick();
    check("R10", 1'b1);
    // pulse coinciding with a write cycle on a full buffer
    cs = 1; wr = 1; crc_end = 1; tick();
    check("R10", 1'b0);
    tick();
    check("R10", 1'b1);
    idle(); tick();
  endtask

  task automatic t_crc_ignored();
    idle(); fn_en = 1; req_mode = 1; dir_tx = 1; tick();
    crc_end = 1; tick();
    check("R11", 1'b1);
    idle(); fn_en = 1; req_mode = 1; sync_mode = 1; tick();
    crc_end = 1; tick();
    check("R11", 1'b1);
    idle(); fn_en = 1; dir_tx = 1; tx_empty = 1; sync_mode = 1; tick();
    crc_end = 1; tick();
    check("R11", 1'b1);
    idle(); tick();
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_wait_rx();
    t_wait_tx();
    t_req_rx();
    t_req_tx();
    t_holdoff();
    t_crc_pulse();
    t_crc_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule